// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous request/response port and an external 128K x 8 asynchronous static RAM. A request carries an address, a write flag and a byte of write data. It is taken when both valid and ready are high. A read result comes back on a response port as a single-cycle valid pulse. On the memory side the controller drives two chip selects of opposite polarity, an active-low output enable, an active-low write enable and the address. The data bus is split into an outbound byte, an inbound byte and a driver enable.

The controller meets every analogue timing rule by counting clock cycles. Each count is the required time in nanoseconds divided by the clock period, rounded up, with a minimum of one. A read holds both selects and the output enable active for the access count and samples the inbound byte on the last of those cycles. A write has three phases, all with both selects active and the output enable inactive:
- a settle phase, with the drivers off, long enough for a previous read's outputs to float;
- a write-enable pulse that is long enough for both the minimum pulse width and the data setup time;
- a hold phase, with write enable released and the data still driven, which also pads the write to the minimum cycle time.

Outside an access every memory control line sits in its inactive state. The one exception is the drivers, which stay on only during the write-enable pulse and the hold phase.

Top module: `asram_ctrl`

## Requirements
- R1: While `req_ready` is high, the memory pins are idle: `mem_cs1_n`=1, `mem_cs2`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0. This is also their state from reset.
- R2: A read holds `mem_cs1_n`=0, `mem_cs2`=1 and `mem_oe_n`=0 for exactly RD_CYC consecutive cycles, where RD_CYC is the larger of ceil(T_ACC_NS/CLK_NS) and ceil(T_RC_NS/CLK_NS). `mem_we_n` stays 1 throughout the read, and `mem_oe_n` is never 0 unless both selects are active.
- R3: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. The drivers turn on only after `mem_oe_n` has been high for at least HZ_CYC = ceil(T_HZ_NS/CLK_NS) cycles.
- R4: In a write, `mem_we_n` falls in the (HZ_CYC+1)-th cycle after acceptance. It stays low for exactly PUL_CYC cycles, where PUL_CYC is the larger of ceil(T_WP_NS/CLK_NS) and ceil(T_DW_NS/CLK_NS). Both selects are active for the whole time it is low.
- R5: `mem_dq_out` equals the request's write data and `mem_dq_oe` is 1 on every cycle in which `mem_we_n` is low. Both also hold in the first cycle after `mem_we_n` rises, so the byte is captured at the trailing edge of the overlap.
- R6: The read byte is the value on `mem_dq_in` in the last cycle of the read access. It is shown on `rsp_data` with `rsp_valid` high for exactly one cycle, the cycle right after the selects are released.
- R7: `req_ready` is low from the cycle after acceptance for exactly RD_CYC cycles for a read. For a write it is low for HZ_CYC+PUL_CYC+HLD_CYC cycles, where HLD_CYC is the larger of 1 and ceil(T_WC_NS/CLK_NS)-HZ_CYC-PUL_CYC.
- R8: `mem_addr` equals the accepted request address and stays stable on every cycle in which a select is active.
- R9: With the default 10 ns clock, RD_CYC=7, HZ_CYC=3, PUL_CYC=6 and HLD_CYC=1. A byte written to an address reads back unchanged at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | 17 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_data | output | 8 | Read data |
| mem_addr | output | 17 | Memory address bus |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data driven toward memory |
| mem_dq_in | input | 8 | Data returned from memory |
| mem_dq_oe | output | 1 | Data driver enable |

## Verification
The hardest situation to reach from the ports is a write that directly follows a read. In that case the memory may still be driving the bus, and only the settle phase keeps the controller's drivers off. The stimulus reaches it by interleaving writes and reads at spread addresses, each issued the moment `req_ready` returns. The bench's pin-level memory model drives `mem_dq_in` only while both selects and the output enable are active, and it stores a byte only at the trailing edge of the select and write-enable overlap. A wrongly timed capture or a contention window therefore shows up as a readback or phase-count mismatch. Sweeps over walking-one addresses, the address extremes and unwritten locations cover the address path in full.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_WSET,
    PH_WPUL,
    PH_WHLD
  } phase_t;

  // ceiling of t_ns / clk_ns, never below one cycle
  function automatic int cyc_of(input int t_ns, input int clk_ns);
    int c;
    c = t_ns / clk_ns;
    if (c * clk_ns < t_ns) c = c + 1;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int RD_CYC  = 7,
  parameter int SET_CYC = 3,
  parameter int PUL_CYC = 6,
  parameter int HLD_CYC = 1,
  parameter int CW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          tmr_done,
  output phase_t        phase_q,
  output phase_t        phase_d,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          accept
);
  assign accept = req_valid && (phase_q == PH_IDLE);

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase_q)
      PH_IDLE: if (req_valid) begin
        tmr_load = 1'b1;
        if (req_write) begin
          phase_d = PH_WSET;
          tmr_val = CW'(SET_CYC - 1);
        end else begin
          phase_d = PH_READ;
          tmr_val = CW'(RD_CYC - 1);
        end
      end
      PH_READ: if (tmr_done) phase_d = PH_IDLE;
      PH_WSET: if (tmr_done) begin
        phase_d  = PH_WPUL;
        tmr_load = 1'b1;
        tmr_val  = CW'(PUL_CYC - 1);
      end
      PH_WPUL: if (tmr_done) begin
        phase_d  = PH_WHLD;
        tmr_load = 1'b1;
        tmr_val  = CW'(HLD_CYC - 1);
      end
      PH_WHLD: if (tmr_done) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/asram_pins.sv
module asram_pins
  import asram_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_t        phase_d,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs1_n,
  output logic          mem_cs2,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_cs1_n <= 1'b1;
      mem_cs2   <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_cs1_n <= (phase_d == PH_IDLE);
      mem_cs2   <= (phase_d != PH_IDLE);
      mem_we_n  <= (phase_d != PH_WPUL);
      mem_oe_n  <= (phase_d != PH_READ);
      mem_dq_oe <= (phase_d == PH_WPUL) || (phase_d == PH_WHLD);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW       = 17,
  parameter int DW       = 8,
  parameter int CLK_NS   = 10,
  parameter int T_ACC_NS = 70,
  parameter int T_RC_NS  = 70,
  parameter int T_WC_NS  = 70,
  parameter int T_WP_NS  = 55,
  parameter int T_DW_NS  = 30,
  parameter int T_HZ_NS  = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs1_n,
  output logic          mem_cs2,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  input  logic [DW-1:0] mem_dq_in,
  output logic          mem_dq_oe
);
  localparam int RD_CYC  = imax(cyc_of(T_ACC_NS, CLK_NS), cyc_of(T_RC_NS, CLK_NS));
  localparam int HZ_CYC  = cyc_of(T_HZ_NS, CLK_NS);
  localparam int PUL_CYC = imax(cyc_of(T_WP_NS, CLK_NS), cyc_of(T_DW_NS, CLK_NS));
  localparam int HLD_CYC = imax(1, cyc_of(T_WC_NS, CLK_NS) - HZ_CYC - PUL_CYC);
  localparam int MAX_CYC = imax(imax(RD_CYC, HZ_CYC), imax(PUL_CYC, HLD_CYC));
  localparam int CW      = $clog2(MAX_CYC + 1);

  phase_t        phase_q, phase_d;
  logic          tmr_load, tmr_done, accept;
  logic [CW-1:0] tmr_val;

  // named internal events, observed by the checker
  logic rd_capture;
  logic wr_strobe_end;

  asram_seq #(
    .RD_CYC(RD_CYC), .SET_CYC(HZ_CYC), .PUL_CYC(PUL_CYC),
    .HLD_CYC(HLD_CYC), .CW(CW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .tmr_done(tmr_done), .phase_q(phase_q), .phase_d(phase_d),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .accept(accept)
  );

  asram_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  asram_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk(clk), .rst_n(rst_n), .phase_d(phase_d), .accept(accept),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_addr(mem_addr),
    .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
  );

  assign req_ready     = (phase_q == PH_IDLE);
  assign rd_capture    = (phase_q == PH_READ) && tmr_done;
  assign wr_strobe_end = (phase_q == PH_WPUL) && tmr_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_capture;
      if (rd_capture) rsp_data <= mem_dq_in;
    end
  end
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int AW      = 17,
  parameter int DW      = 8,
  parameter int HZ_CYC  = 3,
  parameter int PUL_CYC = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs1_n,
  input logic          mem_cs2,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe,
  input logic          rd_capture,
  input logic          wr_strobe_end
);
  logic [15:0] oe_hi_cnt;
  logic [15:0] we_lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_hi_cnt <= 16'(HZ_CYC);
      we_lo_cnt <= '0;
    end else begin
      if (!mem_oe_n)                     oe_hi_cnt <= '0;
      else if (oe_hi_cnt < 16'(HZ_CYC))  oe_hi_cnt <= oe_hi_cnt + 1'b1;
      if (!mem_we_n)                     we_lo_cnt <= we_lo_cnt + 1'b1;
      else                               we_lo_cnt <= '0;
    end
  end

  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe));

  p_read_we_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_cs1_n && mem_cs2));

  p_no_contention_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_float_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_hi_cnt >= 16'(HZ_CYC)));

  p_we_pulse_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_cnt == 16'(PUL_CYC)));

  p_we_selected_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs1_n && mem_cs2));

  p_strobe_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe_end |=> mem_we_n);

  p_wdata_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_dq_out) && mem_dq_oe));

  p_wdata_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_out)));

  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |=> (rsp_valid && mem_oe_n));

  p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs1_n && $past(!mem_cs1_n)) |-> $stable(mem_addr));
endmodule

bind asram_ctrl asram_ctrl_chk #(
  .AW(AW), .DW(DW), .HZ_CYC(HZ_CYC), .PUL_CYC(PUL_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n),
  .mem_cs2(mem_cs2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
  .rd_capture(rd_capture), .wr_strobe_end(wr_strobe_end)
);

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;
  localparam int DW = 8;

  function automatic int up_div(input int t);
    int r;
    r = (t + CLK_PERIOD - 1) / CLK_PERIOD;
    return (r == 0) ? 1 : r;
  endfunction

  localparam int E_RD  = (up_div(70) > up_div(70)) ? up_div(70) : up_div(70);
  localparam int E_HZ  = up_div(30);
  localparam int E_PUL = (up_div(55) > up_div(30)) ? up_div(55) : up_div(30);
  localparam int E_HLD = (up_div(70) - E_HZ - E_PUL > 1) ? up_div(70) - E_HZ - E_PUL : 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] mem_addr;
  logic          mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  asram_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe)
  );

  // pin-level memory model
  logic [DW-1:0] cells [int];
  logic [DW-1:0] sb    [int];

  function automatic logic [DW-1:0] dflt(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {a[16], 7'h35};
  endfunction

  function automatic logic [DW-1:0] cell_rd(input logic [AW-1:0] a);
    return cells.exists(int'(a)) ? cells[int'(a)] : dflt(a);
  endfunction

  always_comb begin
    if (!mem_cs1_n && mem_cs2 && !mem_oe_n && mem_we_n) mem_dq_in = cell_rd(mem_addr);
    else                                                mem_dq_in = 8'hEE;
  end

  logic          ov_prev = 1'b0;
  logic [AW-1:0] ov_addr = '0;
  logic [DW-1:0] ov_data = '0;
  always @(negedge clk) begin
    logic ov_now;
    ov_now = !mem_cs1_n && mem_cs2 && !mem_we_n;
    if (ov_prev && !ov_now) cells[int'(ov_addr)] = ov_data;
    ov_prev = ov_now;
    ov_addr = mem_addr;
    ov_data = mem_dq_oe ? mem_dq_out : 8'hEE;
  end

  task automatic check(input bit ok, input string rq, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, expv);
    end
  endtask

  task automatic idle_check();
    check(req_ready && mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe,
          "R1 idle pins", {req_ready, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe},
          6'b110110);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int busy = 0, we_lo = 0, first_we = -1, first_drv = -1;
    int bad_addr = 0, bad_data = 0, bad_hold = 0, contend = 0, stray = 0;
    bit prev_low = 0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) begin
      busy++;
      if ((!mem_cs1_n || mem_cs2) && mem_addr != a) bad_addr++;
      if (mem_dq_oe && first_drv < 0) first_drv = busy;
      if (!mem_we_n) begin
        if (first_we < 0) first_we = busy;
        we_lo++;
        if (!mem_dq_oe || mem_dq_out != d || mem_cs1_n || !mem_cs2) bad_data++;
      end else if (prev_low) begin
        if (!mem_dq_oe || mem_dq_out != d || mem_cs1_n || !mem_cs2) bad_hold++;
      end
      if (mem_dq_oe && !mem_oe_n) contend++;
      if (!mem_oe_n || rsp_valid) stray++;
      prev_low = !mem_we_n;
      @(negedge clk);
    end
    sb[int'(a)] = d;
    check(busy == E_HZ + E_PUL + E_HLD, "R7 write busy", busy, E_HZ + E_PUL + E_HLD);
    check(we_lo == E_PUL, "R4 we pulse", we_lo, E_PUL);
    check(first_we == E_HZ + 1, "R4 we fall", first_we, E_HZ + 1);
    check(bad_data == 0 && bad_hold == 0, "R5 write data", bad_data + bad_hold, 0);
    check(contend == 0 && first_drv >= E_HZ + 1, "R3 drivers", first_drv, E_HZ + 1);
    check(bad_addr == 0, "R8 address", bad_addr, 0);
    check(stray == 0, "R2 no oe in write", stray, 0);
    idle_check();
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    int busy = 0, act = 0, bad = 0, bad_addr = 0;
    logic [DW-1:0] e;
    e = sb.exists(int'(a)) ? sb[int'(a)] : dflt(a);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 8'h5A;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) begin
      busy++;
      if (!mem_cs1_n && mem_cs2 && !mem_oe_n) act++;
      if (!mem_we_n || mem_dq_oe || rsp_valid) bad++;
      if ((!mem_cs1_n || mem_cs2) && mem_addr != a) bad_addr++;
      @(negedge clk);
    end
    check(act == E_RD && bad == 0, "R2 read strobes", act, E_RD);
    check(busy == E_RD, "R7 read busy", busy, E_RD);
    check(rsp_valid && rsp_data == e, "R6 read data", rsp_data, e);
    check(bad_addr == 0, "R8 address", bad_addr, 0);
    idle_check();
    @(negedge clk);
    check(!rsp_valid, "R6 single pulse", rsp_valid, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R7 watchdog: actual %0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] lst [19];
    for (int i = 0; i < 17; i++) lst[i] = AW'(1) << i;
    lst[17] = '0;
    lst[18] = '1;
    repeat (4) @(negedge clk);
    idle_check();   // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    idle_check();
    // R9: counts at the default clock
    check(E_RD == 7 && E_HZ == 3 && E_PUL == 6 && E_HLD == 1, "R9 counts",
          E_RD * 1000 + E_HZ * 100 + E_PUL * 10 + E_HLD, 7361);
    // unwritten locations read the model's default contents
    do_read(17'h0ABCD);
    do_read(17'h1F00F);
    // sweep: write walking ones and extremes, then read back
    for (int i = 0; i < 19; i++) do_write(lst[i], DW'(i * 37 + 11) ^ lst[i][7:0]);
    for (int i = 0; i < 19; i++) do_read(lst[i]);
    // interleaved write-after-read turnaround, R9 round trip
    for (int i = 0; i < 24; i++) begin
      logic [AW-1:0] a;
      a = AW'(i * 5461 + 3);
      do_read(a);
      do_write(a, DW'(8'hC3 ^ i[7:0]));
      do_read(a);
      check(cell_rd(a) == DW'(8'hC3 ^ i[7:0]), "R9 stored byte", cell_rd(a), 8'hC3 ^ i[7:0]);
    end
    // back-to-back writes to the same address, last one wins
    do_write(17'h00100, 8'h11);
    do_write(17'h00100, 8'hEF);
    do_read(17'h00100);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule